// File: doc/BRIEF.md
# Periodic Interrupt Generator

This block raises the periodic interrupt of a real-time clock. A free-running prescaler counts strobes from the 32.768 kHz timebase. One full wrap of the prescaler is one second. The same prescaler sets the phase of the two fast square-wave settings. The slower settings use boundary strobes from the calendar counters: one when the seconds roll over to 00, one when the minutes and seconds both reach 00, and one on the first instant of day 1 of a month. These settings latch a flag and pull the interrupt line low until software clears the flag.

Software picks one of six periods with a 3-bit select code, or turns the output off. It can poll the flag instead of wiring the pin. In a pulse setting the flag follows the pin. In a level setting a flag write of 0 releases the pin and a flag write of 1 changes nothing. Rewriting the seconds counter clears the prescaler, so the square wave restarts its phase from that write.

Top module: `pirq_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `irq_n` is 1 and `flag` is 0.
- R2: With select code 000 or 111 the output is off. Each clock edge drives `irq_n` to 1 and `flag` to 0, whatever the other inputs are.
- R3: The prescaler counts `osc_en` strobes modulo 2^PRE_W. A `sec_wr` pulse clears it to 0, and this clear wins over an `osc_en` in the same cycle. With code 010, the edge that samples `sec_wr` drives `irq_n` low.
- R4: Code 010 is 1 Hz pulse mode. After each edge, `irq_n` is 0 while the prescaler value is below 2^(PRE_W-1), and 1 otherwise.
- R5: Code 001 is 2 Hz pulse mode. After each edge, `irq_n` is 0 while bit PRE_W-2 of the prescaler is 0, and 1 otherwise.
- R6: In pulse mode `flag` equals the inverse of `irq_n`, and flag writes (`flag_we`) have no effect.
- R7: Code 011 is per-second level mode. The flag is set at the edge where `osc_en` is high with the prescaler all ones and `sec_wr` low.
- R8: Code 100 sets the flag on `min_bnd`, code 101 on `hour_bnd`, and code 110 on `month_bnd`. In each level code, the boundary strobes that belong to other codes are ignored.
- R9: In level mode `irq_n` is the inverse of `flag`. The flag holds until a write with `flag_we`=1 and `flag_wd`=0 clears it at that edge.
- R10: In level mode a write with `flag_wd`=1 leaves the flag unchanged.
- R11: If a level-mode set event and a clearing write arrive in the same cycle, the flag ends up set.
- R12: At the edge where the select code differs from its value at the previous edge, a level-mode flag is cleared, even if a set event arrives in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 3 | Period select code |
| osc_en | input | 1 | One strobe per timebase period |
| sec_wr | input | 1 | Seconds counter was rewritten |
| min_bnd | input | 1 | Seconds rolled over to 00 |
| hour_bnd | input | 1 | Minute and second reached 00 |
| month_bnd | input | 1 | First instant of day 1 |
| flag_we | input | 1 | Flag write strobe |
| flag_wd | input | 1 | Flag write data |
| irq_n | output | 1 | Active-low interrupt, registered |
| flag | output | 1 | Interrupt flag, registered |

## Verification
Two things can land on the same edge: a level-mode set event and the software write that clears the flag. The same holds for a set event and a change of the select code. The bench drives a boundary strobe together with a clearing write and expects the flag to stay set. It drives a select change together with a matching boundary strobe and expects the flag to be cleared. A cycle-accurate model in the bench judges every edge of a sweep over all eight codes. That sweep mixes interleaved strobes with the seconds rewrite that re-phases the prescaler.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  typedef enum logic [2:0] {
    SEL_OFF   = 3'd0,
    SEL_P2HZ  = 3'd1,
    SEL_P1HZ  = 3'd2,
    SEL_LSEC  = 3'd3,
    SEL_LMIN  = 3'd4,
    SEL_LHOUR = 3'd5,
    SEL_LMON  = 3'd6,
    SEL_OFF7  = 3'd7
  } sel_e;

  typedef enum logic [1:0] {
    MODE_OFF,
    MODE_PULSE,
    MODE_LEVEL
  } mode_e;

  function automatic mode_e mode_of(input logic [2:0] code);
    case (code)
      SEL_P2HZ, SEL_P1HZ:                     mode_of = MODE_PULSE;
      SEL_LSEC, SEL_LMIN, SEL_LHOUR, SEL_LMON: mode_of = MODE_LEVEL;
      default:                                mode_of = MODE_OFF;
    endcase
  endfunction
endpackage

// File: rtl/pirq_prescaler.sv
module pirq_prescaler #(
  parameter int PRE_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             osc_en,
  input  logic             sec_wr,
  output logic [PRE_W-1:0] cnt_d,
  output logic             wrap
);
  logic [PRE_W-1:0] cnt_q;

  always_comb begin
    if (sec_wr)      cnt_d = '0;
    else if (osc_en) cnt_d = cnt_q + 1'b1;
    else             cnt_d = cnt_q;
    wrap = osc_en && !sec_wr && (cnt_q == {PRE_W{1'b1}});
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pirq_evt_sel.sv
module pirq_evt_sel
  import pirq_pkg::*;
#(
  parameter int PRE_W = 15
) (
  input  logic [2:0]       sel,
  input  logic [PRE_W-1:0] cnt_d,
  input  logic             wrap,
  input  logic             min_bnd,
  input  logic             hour_bnd,
  input  logic             month_bnd,
  output logic             level_evt,
  output logic             wave_low
);
  localparam int HALF_BIT = PRE_W - 1;
  localparam int QUAR_BIT = PRE_W - 2;

  always_comb begin
    case (sel)
      SEL_LSEC:  level_evt = wrap;
      SEL_LMIN:  level_evt = min_bnd;
      SEL_LHOUR: level_evt = hour_bnd;
      SEL_LMON:  level_evt = month_bnd;
      default:   level_evt = 1'b0;
    endcase
    if (sel == SEL_P1HZ) wave_low = !cnt_d[HALF_BIT];
    else                 wave_low = !cnt_d[QUAR_BIT];
  end
endmodule

// File: rtl/pirq_gen.sv
module pirq_gen
  import pirq_pkg::*;
#(
  parameter int PRE_W = 15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] sel,
  input  logic       osc_en,
  input  logic       sec_wr,
  input  logic       min_bnd,
  input  logic       hour_bnd,
  input  logic       month_bnd,
  input  logic       flag_we,
  input  logic       flag_wd,
  output logic       irq_n,
  output logic       flag
);
  logic [PRE_W-1:0] cnt_d;
  logic             wrap;
  logic             level_evt;
  logic             wave_low;
  logic [2:0]       sel_q;
  logic             sel_chg;
  logic             flag_d;

  pirq_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .osc_en(osc_en), .sec_wr(sec_wr),
    .cnt_d(cnt_d), .wrap(wrap)
  );

  pirq_evt_sel #(.PRE_W(PRE_W)) u_evt (
    .sel(sel), .cnt_d(cnt_d), .wrap(wrap), .min_bnd(min_bnd),
    .hour_bnd(hour_bnd), .month_bnd(month_bnd),
    .level_evt(level_evt), .wave_low(wave_low)
  );

  assign sel_chg = (sel != sel_q);

  always_comb begin
    case (mode_of(sel))
      MODE_PULSE: flag_d = wave_low;
      MODE_LEVEL: begin
        if (sel_chg)                 flag_d = 1'b0;
        else if (level_evt)          flag_d = 1'b1;
        else if (flag_we && !flag_wd) flag_d = 1'b0;
        else                         flag_d = flag;
      end
      default:    flag_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 3'd0;
      flag  <= 1'b0;
      irq_n <= 1'b1;
    end else begin
      sel_q <= sel;
      flag  <= flag_d;
      irq_n <= !flag_d;
    end
  end
endmodule

// File: rtl/pirq_gen_chk.sv
module pirq_gen_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] sel,
  input logic       osc_en,
  input logic       sec_wr,
  input logic       min_bnd,
  input logic       hour_bnd,
  input logic       month_bnd,
  input logic       flag_we,
  input logic       flag_wd,
  input logic       irq_n,
  input logic       flag
);
  logic lvl;
  assign lvl = (sel >= 3'd3) && (sel <= 3'd6);

  AST_OFF_PIN_HIGH: assert property (@(posedge clk) disable iff (rst)
    (sel == 3'd0 || sel == 3'd7) |=> (irq_n && !flag)); // R2

  AST_RESYNC_LOW: assert property (@(posedge clk) disable iff (rst)
    (sec_wr && sel == 3'd2) |=> !irq_n); // R3

  AST_ONE_NOOP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && lvl && $stable(sel) && flag && flag_we && flag_wd) |=> flag); // R10

  AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && lvl && $stable(sel) && flag_we && !flag_wd && !osc_en
     && !min_bnd && !hour_bnd && !month_bnd) |=> !flag); // R9

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && sel == 3'd4 && $stable(sel) && min_bnd) |=> flag); // R11
endmodule

bind pirq_gen pirq_gen_chk u_chk (
  .clk(clk), .rst(rst), .sel(sel), .osc_en(osc_en), .sec_wr(sec_wr),
  .min_bnd(min_bnd), .hour_bnd(hour_bnd), .month_bnd(month_bnd),
  .flag_we(flag_we), .flag_wd(flag_wd), .irq_n(irq_n), .flag(flag)
);

// File: tb/pirq_gen_tb.sv
module pirq_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 4;
  localparam int SEC = 1 << PW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] sel = 3'd0;
  logic osc_en = 1'b0, sec_wr = 1'b0, min_bnd = 1'b0, hour_bnd = 1'b0;
  logic month_bnd = 1'b0, flag_we = 1'b0, flag_wd = 1'b0;
  logic irq_n, flag;

  int checks = 0;
  int errors = 0;
  int ref_cnt = 0;
  bit exp_flag = 1'b0;
  logic [2:0] sel_prev = 3'd0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pirq_gen #(.PRE_W(PW)) u_dut (
    .clk(clk), .rst(rst), .sel(sel), .osc_en(osc_en), .sec_wr(sec_wr),
    .min_bnd(min_bnd), .hour_bnd(hour_bnd), .month_bnd(month_bnd),
    .flag_we(flag_we), .flag_wd(flag_wd), .irq_n(irq_n), .flag(flag)
  );

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // apply inputs, advance one edge, update the model, check outputs at negedge
  task automatic step(input string tag, input bit o, input bit sw, input bit mb,
                      input bit hb, input bit mob, input bit we, input bit wd);
    bit wrap, chg, evt;
    osc_en = o; sec_wr = sw; min_bnd = mb; hour_bnd = hb; month_bnd = mob;
    flag_we = we; flag_wd = wd;
    @(posedge clk);
    chg = (sel != sel_prev);
    sel_prev = sel;
    wrap = o && !sw && (ref_cnt == SEC - 1);
    if (sw) ref_cnt = 0;
    else if (o) ref_cnt = (ref_cnt + 1) % SEC;
    case (sel)
      3'd1: exp_flag = ((ref_cnt % (SEC/2)) < (SEC/4));
      3'd2: exp_flag = (ref_cnt < (SEC/2));
      3'd3, 3'd4, 3'd5, 3'd6: begin
        evt = (sel == 3'd3) ? wrap : (sel == 3'd4) ? mb : (sel == 3'd5) ? hb : mob;
        if (chg) exp_flag = 1'b0;
        else if (evt) exp_flag = 1'b1;
        else if (we && !wd) exp_flag = 1'b0;
      end
      default: exp_flag = 1'b0;
    endcase
    @(negedge clk);
    check(tag, flag, exp_flag, "flag");
    check(tag, irq_n, !exp_flag, "irq_n");
    osc_en = 0; sec_wr = 0; min_bnd = 0; hour_bnd = 0; month_bnd = 0;
    flag_we = 0; flag_wd = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    sel = 3'd3;
    repeat (3) @(negedge clk);
    check("R1", irq_n, 1'b1, "irq_n in reset");
    check("R1", flag, 1'b0, "flag in reset");
    rst = 1'b0;
    sel = 3'd0;
    step("R1", 1, 0, 0, 0, 0, 0, 0);
    // off codes
    for (int i = 0; i < 20; i++) step("R2", 1, i == 3, i[0], i[1], i[2], 1, 1);
    sel = 3'd7;
    for (int i = 0; i < 6; i++) step("R2", 1, 0, 1, 1, 1, 0, 0);
    // 1 Hz pulse, re-phased by seconds write with simultaneous osc strobe
    sel = 3'd2;
    step("R3", 1, 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 40; i++) step("R4", 1, 0, 0, 0, 0, 0, 0);
    step("R6", 1, 0, 0, 0, 0, 1, 0);
    step("R6", 1, 0, 0, 0, 0, 1, 1);
    for (int i = 0; i < 3; i++) step("R3", 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) step("R4", 1, 0, 0, 0, 0, 0, 0);
    step("R3", 1, 1, 0, 0, 0, 0, 0);
    // 2 Hz pulse
    sel = 3'd1;
    for (int i = 0; i < 24; i++) step("R5", 1, i == 13, 0, 0, 0, i == 5, 0);
    // per-second level
    sel = 3'd3;
    for (int i = 0; i < 40; i++) step("R7", 1, 0, 1, 1, 1, 0, 0);
    step("R10", 0, 0, 0, 0, 0, 1, 1);
    step("R9", 0, 0, 0, 0, 0, 1, 0);
    for (int i = 0; i < 3; i++) step("R9", 0, 0, 0, 0, 0, 0, 0);
    // minute level: foreign strobes ignored, set and clear together
    sel = 3'd4;
    step("R12", 0, 0, 1, 0, 0, 0, 0);
    for (int i = 0; i < 20; i++) step("R8", 1, 0, 0, 1, 1, 0, 0);
    step("R8", 0, 0, 1, 0, 0, 0, 0);
    step("R10", 1, 0, 0, 0, 0, 1, 1);
    step("R9", 0, 0, 0, 0, 0, 1, 0);
    step("R11", 0, 0, 1, 0, 0, 1, 0);
    // hour and month level, change of select clears
    sel = 3'd5;
    step("R12", 0, 0, 0, 0, 0, 0, 0);
    step("R8", 0, 0, 1, 0, 1, 0, 0);
    step("R8", 0, 0, 0, 1, 0, 0, 0);
    sel = 3'd6;
    step("R12", 0, 0, 0, 0, 1, 0, 0);
    step("R8", 0, 0, 1, 1, 0, 0, 0);
    step("R8", 0, 0, 0, 0, 1, 0, 0);
    step("R11", 0, 0, 0, 0, 1, 1, 0);
    // sweep over all codes with interleaved strobes
    for (int s = 0; s < 8; s++) begin
      sel = 3'(s);
      for (int i = 0; i < 48; i++)
        step("R12", (i % 3) != 0, (i % 13) == 5, (i % 7) == 1, (i % 9) == 2,
             (i % 11) == 3, (i % 5) == 4, (i % 10) == 9);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule